// File: doc/BRIEF.md
# Serial Register and Scratch RAM Front End for a Real-Time Clock

This block is the host-facing slave of a real-time clock. A host drives a four-wire serial link in clock mode 3, with the clock idling high, data sampled on the rising edge and launched on the falling edge. Every frame opens with one command byte. That byte picks read or write, register space or RAM space, and a five-bit location. The frame then carries one data byte, or a burst of bytes when the location is the all-ones burst code. The block holds the control, century and alarm registers and a 31-byte scratch RAM. The time-of-day counters stay in a separate time block, and this block reaches them through three strobes: snapshot, commit and abort.

All logic runs on one system clock. The serial pins pass through synchronizers and are edge-detected inside the block. For that to work, each SCLK high phase and each SCLK low phase must last at least eight system clock cycles. Time writes collect in a staging buffer. That buffer is handed to the time block only when the frame closes, and only if the write was complete. Time reads are served from a snapshot taken when the command byte ends.

Top module: `spi_rtc_regif`

## Requirements
- R1: Command byte fields, MSB first: bit 7 = 1 for read, bit 6 = 1 for RAM space, bits 5..1 = location, bit 0 must be 1. A write command with bit 0 = 0 changes no register and no RAM byte.
- R2: The device samples DIN on the rising edge of SCLK and changes DOUT on the falling edge, MSB first. The first read data bit is valid before the first rising edge that follows the command byte.
- R3: dout_oe is 0 while CS_n is high and throughout any frame whose command is a write. It is 1 while read data is being shifted out.
- R4: Commands 3Fh (write) and BFh (read) address the clock burst. Its bytes run seconds, minutes, hours, date, month, weekday, year, control. Time field i occupies bits [8i+7:8i] of the time buses.
- R5: A clock burst write takes effect only when all eight data bytes arrive before CS_n rises. A shorter burst pulses abort_o and leaves both the time block and the control register unchanged.
- R6: Commands 7Fh (write) and FFh (read) address the RAM burst, which starts at RAM 0. Each completed byte is stored at once. A burst read returns the 31 bytes in order and then returns 00h. Single RAM locations are at write 41h+2n and read C1h+2n.
- R7: In a single write, only the first data byte counts. Further bytes in the same frame are ignored.
- R8: Control is location 7 (write 0Fh, read 8Fh). Its bit 7 is the write-protect flag and bits 6..0 read as 0. While the flag is set, writes to every location except control are dropped, and no commit is produced.
- R9: Century (location 9, read 93h) is not part of the clock burst. A write to location 11 (17h) is ignored, and unmapped locations read as 00h.
- R10: A read command aimed at a time location or at the clock burst pulses snap_o and captures live_time_i when the command byte ends. Later changes of live_time_i are not seen in that frame.
- R11: A permitted, complete time write pulses commit_o once, after CS_n rises. new_mask_o marks the written fields: one bit for a single write, all seven for a burst.
- R12: Any read or write command for the alarm configuration (location 10) or an alarm threshold (locations 12..18) pulses alm_clr_o. A command for any other location does not.
- R13: After reset, control is 00h and century is 19h. The alarm configuration is 00h. The alarm thresholds, seconds through year, are 7Fh, 7Fh, BFh, 3Fh, 1Fh, 07h, FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Frame select, active low |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for the DOUT pad |
| live_time_i | input | 56 | Current time fields from the time block |
| snap_o | output | 1 | Pulse: snapshot taken |
| commit_o | output | 1 | Pulse: load new_time_o fields into the time block |
| abort_o | output | 1 | Pulse: time write discarded |
| new_time_o | output | 56 | Staged time fields |
| new_mask_o | output | 7 | Fields valid in the last commit |
| wp_o | output | 1 | Write-protect flag |
| century_o | output | 8 | Century register |
| alm_cfg_o | output | 8 | Alarm field-enable register |
| alm_thr_o | output | 56 | Alarm thresholds, same field order as time |
| alm_clr_o | output | 1 | Pulse: clear the alarm flag |

## Verification
A bit counter or byte index that drifts shows up on the next read as a rotated or shifted value. A pointer that is off shows up as a field taken from the wrong place, and the bench sees either one within the same frame. A stale staging mask or completion flag shows up at the next rising edge of CS_n, as a commit in place of an abort or as a wrong new_mask_o. A write-protect flag that leaks shows up on the read-back that follows the blocked write. A snapshot taken at the wrong moment shows up as values that track live_time_i, which the bench changes in the middle of the frame.

// File: rtl/spi_rtc_pkg.sv
`timescale 1ns/1ps
package spi_rtc_pkg;
  localparam logic [4:0] LOC_CTRL  = 5'd7;
  localparam logic [4:0] LOC_CENT  = 5'd9;
  localparam logic [4:0] LOC_ACFG  = 5'd10;
  localparam logic [4:0] LOC_THR0  = 5'd12;
  localparam logic [4:0] LOC_THRN  = 5'd18;
  localparam logic [4:0] LOC_BURST = 5'd31;

  typedef struct packed {
    logic       rd;
    logic       ram;
    logic [4:0] loc;
    logic       en;
  } cmd_t;

  function automatic logic [7:0] thr_rst(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2:       return 8'hBF;
      3:       return 8'h3F;
      4:       return 8'h1F;
      5:       return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_alarm_loc(input logic [4:0] loc);
    return (loc == LOC_ACFG) || ((loc >= LOC_THR0) && (loc <= LOC_THRN));
  endfunction
endpackage

// File: rtl/spi_rtc_sync.sv
`timescale 1ns/1ps
module spi_rtc_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= {STAGES{RST_VAL[g]}};
      else     sr <= {sr[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/spi_rtc_shift.sv
`timescale 1ns/1ps
module spi_rtc_shift #(
  parameter int DW    = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             din_i,
  input  logic             rd_mode_i,
  input  logic [DW-1:0]    tx_data_i,
  output logic             byte_done_o,
  output logic [DW-1:0]    rx_byte_o,
  output logic [IDX_W-1:0] rx_num_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  localparam int BC_W = $clog2(DW);

  logic [BC_W-1:0]  bitcnt;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    tx_sh;
  logic [IDX_W-1:0] num;

  always_ff @(posedge clk) begin
    if (rst || !cs_act_i) begin
      bitcnt      <= '0;
      num         <= '0;
      tx_sh       <= '0;
      dout_oe_o   <= 1'b0;
      byte_done_o <= 1'b0;
      if (rst) begin
        rx_sh     <= '0;
        rx_byte_o <= '0;
        rx_num_o  <= '0;
      end
    end else begin
      byte_done_o <= 1'b0;
      if (sclk_rise_i) begin
        rx_sh  <= {rx_sh[DW-2:0], din_i};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == BC_W'(DW-1)) begin
          byte_done_o <= 1'b1;
          rx_byte_o   <= {rx_sh[DW-2:0], din_i};
          rx_num_o    <= num;
          if (num != '1) num <= num + 1'b1;
        end
      end
      if (sclk_fall_i && rd_mode_i && (num != '0)) begin
        if (bitcnt == '0) begin
          tx_sh     <= tx_data_i;
          dout_oe_o <= 1'b1;
        end else begin
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign dout_o = tx_sh[DW-1];

  AST_OE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    !cs_act_i |=> !dout_oe_o); // R3
  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    dout_oe_o |-> rd_mode_i); // R3
endmodule

// File: rtl/spi_rtc_ram.sv
`timescale 1ns/1ps
module spi_rtc_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 31,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  AST_RAM_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    we_i |-> (int'(waddr_i) < DEPTH)); // R6
endmodule

// File: rtl/spi_rtc_regif.sv
`timescale 1ns/1ps
module spi_rtc_regif
  import spi_rtc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int RAM_DEPTH   = 31,
  parameter int N_TIME      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 din,
  output logic                 dout,
  output logic                 dout_oe,
  input  logic [N_TIME*DW-1:0] live_time_i,
  output logic                 snap_o,
  output logic                 commit_o,
  output logic                 abort_o,
  output logic [N_TIME*DW-1:0] new_time_o,
  output logic [N_TIME-1:0]    new_mask_o,
  output logic                 wp_o,
  output logic [DW-1:0]        century_o,
  output logic [DW-1:0]        alm_cfg_o,
  output logic [N_TIME*DW-1:0] alm_thr_o,
  output logic                 alm_clr_o
);
  localparam int   AW      = $clog2(RAM_DEPTH + 1);
  localparam int   PTR_W   = AW + 1;
  localparam int   TIME_W  = N_TIME * DW;
  localparam logic [PTR_W-1:0] PTR_RAM_END = PTR_W'(RAM_DEPTH);
  localparam logic [PTR_W-1:0] PTR_CTRL    = PTR_W'(N_TIME);
  localparam logic [4:0]       LOC_NTIME   = 5'(N_TIME);

  // pin synchronizers and edge detection
  logic [2:0] pins_q;
  logic       sclk_prev, csn_prev;
  spi_rtc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst), .d_i({din, cs_n, sclk}), .q_o(pins_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b1;
      csn_prev  <= 1'b1;
    end else begin
      sclk_prev <= pins_q[0];
      csn_prev  <= pins_q[1];
    end
  end

  logic sclk_rise, sclk_fall, cs_act, cs_end;
  assign sclk_rise = pins_q[0] & ~sclk_prev;
  assign sclk_fall = ~pins_q[0] & sclk_prev;
  assign cs_act    = ~pins_q[1];
  assign cs_end    = pins_q[1] & ~csn_prev;

  // byte engine
  logic             byte_done, rd_mode;
  logic [DW-1:0]    rx_byte, rd_byte;
  logic [IDX_W-1:0] rx_num;
  spi_rtc_shift #(.DW(DW), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst(rst), .cs_act_i(cs_act), .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall), .din_i(pins_q[2]), .rd_mode_i(rd_mode),
    .tx_data_i(rd_byte), .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .rx_num_o(rx_num), .dout_o(dout), .dout_oe_o(dout_oe));

  // scratch RAM
  logic             ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [DW-1:0]    ram_wdata, ram_rdata;
  logic [PTR_W-1:0] ptr;
  spi_rtc_ram #(.DW(DW), .DEPTH(RAM_DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i((ptr < PTR_RAM_END) ? ptr[AW-1:0] : '0), .rdata_o(ram_rdata));

  // frame and register state
  cmd_t             cmd;
  logic             cur_ram, burst, wr_ok, clk_pend, wr_full, ctl_buf, wp_q;
  logic [4:0]       cur_loc;
  logic [TIME_W-1:0] snap_q, tbuf, thr_q;
  logic [N_TIME-1:0] mask_acc;
  logic [DW-1:0]    cent_q, acfg_q;

  assign cmd = cmd_t'(rx_byte[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_o <= 1'b0; commit_o <= 1'b0; abort_o <= 1'b0; alm_clr_o <= 1'b0;
      ram_we <= 1'b0; ram_waddr <= '0; ram_wdata <= '0;
      rd_mode <= 1'b0; wr_ok <= 1'b0; clk_pend <= 1'b0; wr_full <= 1'b0;
      burst <= 1'b0; cur_ram <= 1'b0; cur_loc <= '0; ptr <= '0; ctl_buf <= 1'b0;
      mask_acc <= '0; new_mask_o <= '0; snap_q <= '0; tbuf <= '0;
      wp_q <= 1'b0; cent_q <= DW'(8'h19); acfg_q <= '0;
      for (int i = 0; i < N_TIME; i++) thr_q[i*DW +: DW] <= DW'(thr_rst(i));
    end else begin
      snap_o <= 1'b0; commit_o <= 1'b0; abort_o <= 1'b0; alm_clr_o <= 1'b0;
      ram_we <= 1'b0;
      if (cs_end && clk_pend) begin
        if (wr_full) begin
          commit_o   <= 1'b1;
          new_mask_o <= mask_acc;
          if (burst) wp_q <= ctl_buf;
        end else begin
          abort_o <= 1'b1;
        end
      end
      if (!cs_act) begin
        rd_mode <= 1'b0; wr_ok <= 1'b0; clk_pend <= 1'b0;
        wr_full <= 1'b0; mask_acc <= '0; burst <= 1'b0;
      end else if (byte_done) begin
        if (rx_num == '0) begin
          cur_ram  <= cmd.ram;
          cur_loc  <= cmd.loc;
          rd_mode  <= cmd.rd;
          burst    <= (cmd.loc == LOC_BURST);
          ptr      <= (cmd.loc == LOC_BURST) ? '0 : PTR_W'(cmd.loc);
          wr_ok    <= !cmd.rd && cmd.en && (!wp_q || (!cmd.ram && cmd.loc == LOC_CTRL));
          clk_pend <= !cmd.rd && cmd.en && !wp_q && !cmd.ram &&
                      ((cmd.loc < LOC_NTIME) || (cmd.loc == LOC_BURST));
          if (cmd.rd && !cmd.ram && ((cmd.loc < LOC_NTIME) || (cmd.loc == LOC_BURST))) begin
            snap_o <= 1'b1;
            snap_q <= live_time_i;
          end
          if (!cmd.ram && is_alarm_loc(cmd.loc)) alm_clr_o <= 1'b1;
        end else begin
          if (burst && (ptr < PTR_RAM_END)) ptr <= ptr + 1'b1;
          if (wr_ok && (burst || rx_num == IDX_W'(1))) begin
            if (cur_ram) begin
              if (ptr < PTR_RAM_END) ram_we <= 1'b1;
              ram_waddr <= ptr[AW-1:0];
              ram_wdata <= rx_byte;
            end else if (burst) begin
              if (ptr < PTR_CTRL) begin
                tbuf[int'(ptr)*DW +: DW] <= rx_byte;
              end else if (ptr == PTR_CTRL) begin
                ctl_buf  <= rx_byte[DW-1];
                wr_full  <= 1'b1;
                mask_acc <= '1;
              end
            end else if (cur_loc < LOC_NTIME) begin
              tbuf[int'(cur_loc)*DW +: DW] <= rx_byte;
              mask_acc[cur_loc]            <= 1'b1;
              wr_full                      <= 1'b1;
            end else if (cur_loc == LOC_CTRL) begin
              wp_q <= rx_byte[DW-1];
            end else if (cur_loc == LOC_CENT) begin
              cent_q <= rx_byte;
            end else if (cur_loc == LOC_ACFG) begin
              acfg_q <= rx_byte;
            end else if ((cur_loc >= LOC_THR0) && (cur_loc <= LOC_THRN)) begin
              thr_q[int'(cur_loc - LOC_THR0)*DW +: DW] <= rx_byte;
            end
          end
        end
      end
    end
  end

  // read data selection
  always_comb begin
    rd_byte = '0;
    if (cur_ram) begin
      if (ptr < PTR_RAM_END) rd_byte = ram_rdata;
    end else if (burst && ptr > PTR_CTRL) begin
      rd_byte = '0;
    end else if (ptr < PTR_CTRL) begin
      rd_byte = snap_q[int'(ptr)*DW +: DW];
    end else if (ptr == PTR_CTRL) begin
      rd_byte = {wp_q, {(DW-1){1'b0}}};
    end else if (ptr == PTR_W'(LOC_CENT)) begin
      rd_byte = cent_q;
    end else if (ptr == PTR_W'(LOC_ACFG)) begin
      rd_byte = acfg_q;
    end else if ((ptr >= PTR_W'(LOC_THR0)) && (ptr <= PTR_W'(LOC_THRN))) begin
      rd_byte = thr_q[int'(ptr - PTR_W'(LOC_THR0))*DW +: DW];
    end
  end

  assign new_time_o = tbuf;
  assign wp_o       = wp_q;
  assign century_o  = cent_q;
  assign alm_cfg_o  = acfg_q;
  assign alm_thr_o  = thr_q;

  AST_COMMIT_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> !$past(cs_act)); // R11
  AST_COMMIT_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (($countones(new_mask_o) == 1) || (new_mask_o == '1))); // R11
  AST_WP_BLOCKS_RAM: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !wp_q); // R8
  AST_SNAP_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(snap_q) |-> snap_o); // R10
endmodule

// File: tb/spi_rtc_regif_tb.sv
`timescale 1ns/1ps
module spi_rtc_regif_tb;
  localparam int HP = 100;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_oe, snap, commit, abort, wp, alm_clr;
  logic [55:0] live_time = 56'h0;
  logic [55:0] new_time, thr;
  logic [6:0]  new_mask;
  logic [7:0]  century, acfg;

  spi_rtc_regif u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .live_time_i(live_time),
    .snap_o(snap), .commit_o(commit), .abort_o(abort),
    .new_time_o(new_time), .new_mask_o(new_mask), .wp_o(wp),
    .century_o(century), .alm_cfg_o(acfg), .alm_thr_o(thr), .alm_clr_o(alm_clr));

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int c_commit = 0, c_abort = 0, c_snap = 0, c_alm = 0, c_oe = 0;
  logic [55:0] last_time = '0;
  logic [6:0]  last_mask = '0;
  logic        done = 1'b0;

  always @(posedge clk) begin
    if (commit) begin c_commit++; last_time <= new_time; last_mask <= new_mask; end
    if (abort)   c_abort++;
    if (snap)    c_snap++;
    if (alm_clr) c_alm++;
    if (dout_oe) c_oe++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; din = tx[i]; #HP;
      rx[i] = dout; oe_all &= dout_oe;
      sclk = 1'b1; #HP;
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; #HP; endtask
  task automatic cs_hi(); cs_n = 1'b1; #(4*HP); endtask

  task automatic wr1(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r; logic o;
    cs_lo(); xfer(c, r, o); xfer(d, r, o); cs_hi();
  endtask

  task automatic rd1(input logic [7:0] c, output logic [7:0] v);
    logic [7:0] r; logic o;
    cs_lo(); xfer(c, r, o); xfer(8'h00, v, o); cs_hi();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R3 idle oe", dout_oe, 0);
    check("R13 century pin", century, 8'h19);
    check("R13 wp pin", wp, 0);
    rd1(8'h8F, v); check("R13 control", v, 8'h00);
    rd1(8'h93, v); check("R13 century", v, 8'h19);
    rd1(8'h95, v); check("R13 alarm cfg", v, 8'h00);
    rd1(8'h9D, v); check("R13 hours threshold", v, 8'hBF);
    check("R13 year threshold pin", thr[55:48], 8'hFF);
  endtask

  task automatic t_burst_write();
    logic [7:0] r; logic o;
    int c0 = c_commit, e0 = c_oe;
    logic [7:0] d [8] = '{8'h31, 8'h11, 8'hB0, 8'h04, 8'h07, 8'h05, 8'h02, 8'h00};
    cs_lo(); xfer(8'h3F, r, o);
    for (int i = 0; i < 8; i++) xfer(d[i], r, o);
    cs_hi();
    check("R5 full burst commits", c_commit, c0 + 1);
    check("R11 burst mask", last_mask, 7'h7F);
    check("R4 burst field order", last_time, 56'h02_05_07_04_B0_11_31);
    check("R3 no oe in write", c_oe, e0);
  endtask

  task automatic t_partial();
    logic [7:0] r; logic o;
    int c0 = c_commit, a0 = c_abort;
    cs_lo(); xfer(8'h3F, r, o);
    for (int i = 0; i < 5; i++) xfer(8'h55, r, o);
    cs_hi();
    check("R5 partial no commit", c_commit, c0);
    check("R5 partial abort", c_abort, a0 + 1);
    check("R5 control untouched", wp, 0);
  endtask

  task automatic t_snapshot();
    logic [7:0] v; logic o;
    logic [55:0] old = 56'h24_03_12_28_23_59_58;
    int s0 = c_snap;
    live_time = old;
    #(4*HP);
    cs_lo(); xfer(8'hBF, v, o);
    live_time = 56'h25_04_01_01_00_00_00;
    for (int i = 0; i < 7; i++) begin
      xfer(8'h00, v, o);
      check("R10 R4 snapshot field", v, old[i*8 +: 8]);
      check("R2 R3 oe during read", o, 1);
    end
    xfer(8'h00, v, o);
    check("R4 control last", v, 8'h00);
    cs_hi();
    check("R10 snap strobe", c_snap, s0 + 1);
  endtask

  task automatic t_single();
    logic [7:0] r, v; logic o;
    int c0 = c_commit;
    cs_lo(); xfer(8'h03, r, o); xfer(8'h45, r, o); xfer(8'h99, r, o); cs_hi();
    check("R11 single commit", c_commit, c0 + 1);
    check("R11 single mask", last_mask, 7'h02);
    check("R7 first byte kept", last_time[15:8], 8'h45);
    cs_lo(); xfer(8'h13, r, o); xfer(8'h20, r, o); xfer(8'h77, r, o); cs_hi();
    rd1(8'h93, v); check("R7 extra byte ignored", v, 8'h20);
  endtask

  task automatic t_ram();
    logic [7:0] r, v; logic o;
    wr1(8'h4B, 8'hA5);
    rd1(8'hCB, v); check("R6 R1 single RAM", v, 8'hA5);
    cs_lo(); xfer(8'h7F, r, o);
    xfer(8'h3C, r, o); xfer(8'h5A, r, o); xfer(8'h69, r, o);
    cs_hi();
    cs_lo(); xfer(8'hFF, r, o);
    for (int i = 0; i < 33; i++) begin
      xfer(8'h00, v, o);
      if (i == 0) check("R6 burst byte 0", v, 8'h3C);
      if (i == 1) check("R6 burst byte 1", v, 8'h5A);
      if (i == 2) check("R6 burst byte 2", v, 8'h69);
      if (i == 5) check("R6 burst byte 5", v, 8'hA5);
      if (i >= 31) check("R6 past end zero", v, 8'h00);
    end
    cs_hi();
  endtask

  task automatic t_wp();
    logic [7:0] r, v; logic o;
    int c0, a0;
    wr1(8'h0F, 8'hFF);
    rd1(8'h8F, v); check("R8 control low bits zero", v, 8'h80);
    check("R8 wp pin", wp, 1);
    wr1(8'h4B, 8'h11);
    rd1(8'hCB, v); check("R8 RAM protected", v, 8'hA5);
    wr1(8'h13, 8'h55);
    rd1(8'h93, v); check("R8 century protected", v, 8'h20);
    c0 = c_commit; a0 = c_abort;
    wr1(8'h01, 8'h12);
    check("R8 time write blocked", c_commit, c0);
    check("R8 no abort when blocked", c_abort, a0);
    wr1(8'h0F, 8'h00);
    rd1(8'h8F, v); check("R8 control unlock", v, 8'h00);
    cs_lo(); xfer(8'h3F, r, o);
    for (int i = 0; i < 8; i++) xfer((i == 7) ? 8'h80 : 8'h00, r, o);
    cs_hi();
    check("R4 burst control applied", wp, 1);
    wr1(8'h0F, 8'h00);
    check("R8 unlock again", wp, 0);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr1(8'h12, 8'h33);
    rd1(8'h93, v); check("R1 bit0 clear blocks reg", v, 8'h20);
    wr1(8'h4A, 8'h00);
    rd1(8'hCB, v); check("R1 bit0 clear blocks RAM", v, 8'hA5);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr1(8'h17, 8'h55);
    rd1(8'h97, v); check("R9 reserved ignored", v, 8'h00);
    rd1(8'h91, v); check("R9 unmapped reads zero", v, 8'h00);
    rd1(8'h93, v); check("R9 century outside burst", v, 8'h20);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    int a0 = c_alm;
    wr1(8'h19, 8'h30);
    rd1(8'h99, v); check("R12 threshold readback", v, 8'h30);
    check("R12 threshold pin", thr[7:0], 8'h30);
    check("R12 clear pulses", c_alm, a0 + 2);
    rd1(8'h8F, v);
    check("R12 no clear for control", c_alm, a0 + 2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #(4*HP);
    t_reset();
    t_burst_write();
    t_partial();
    t_snapshot();
    t_single();
    t_ram();
    t_wp();
    t_enable();
    t_reserved();
    t_alarm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule